// File: doc/BRIEF.md
# Two-Channel Byte Transfer Engine with Bus Handshake

This block moves single bytes between memory and two serial channels. A transmit channel asks for a byte to be read from memory, and a receive channel asks for a byte to be written to memory. Each channel owns a 16-bit address counter. Software or a neighbouring block presets the counter, and the counter steps by one after every completed byte, so it always holds the next address to use.

For every accepted request the engine raises a bus request and waits for the grant. It then runs three one-clock phases. In the address phase the low address byte goes out on its own pins, the high address byte goes out on the shared address/data bus, and the address strobe pulses for an external latch. In the strobe phase the memory read or write strobe is raised. In the release phase the channel is acknowledged. The bus request drops in the cycle after release. Every bus-side output has an output-enable flag, and these flags are high only between the grant and the release.

Each channel interface follows valid/ready rules. The valid signal is raised to ask for one byte. It must stay high, with `rx_byte` stable, until ready is seen. A byte transfer completes on the clock edge where valid and ready are both high. If valid is still high in the next cycle, that counts as a new request. Ready cannot be forced by the channel: it appears only in the release phase. The engine keeps track of which request arrived first. Requests that become pending in the same cycle are settled in favour of the receive channel.

Top module: `twin_byte_dma`

## Requirements
- R1: While `mrst` is high, and in the first cycle after it falls, the bus request is inactive, every output enable, strobe and ready is low, and both address counters read 0x0000. Raising `mrst` part-way through a transfer abandons that transfer.
- R2: With `pol_low`=1, the request and grant pins are active-low. With `pol_low`=0 they are active-high.
- R3: An accepted request drives the bus request active in the next cycle. The first clock after the grant is seen is the address phase: `adr_strobe`=1, `ad_oe`=1, `ad_o` carries address bits 15:8, and `mem_a_lo` carries bits 7:0. The strobe phase and then the release phase follow, one clock each. The bus request is inactive in the cycle after release.
- R4: A transmit transfer raises `mem_rd` only in the strobe phase, with `ad_oe`=0. `ad_i` is sampled at the end of that phase, and the sampled value appears on `tx_byte` while `tx_ready` is high.
- R5: A receive transfer raises `mem_wr` only in the strobe phase, and drives `rx_byte` on `ad_o` with `ad_oe`=1.
- R6: Each accepted request produces exactly one bus cycle and exactly one single-cycle ready pulse, on the channel that was picked.
- R7: Requests from both channels that become pending in the same cycle are served receive first, then transmit.
- R8: Otherwise the channel whose pending request is older is served first. A valid that is held past its ready counts as a new request that is younger than one already waiting.
- R9: A counter steps by one, modulo 2^16, after each of its own transfers. For example, 0xFFFF is followed by 0x0000, and a carry out of bit 7 reaches the high byte.
- R10: `bus_oe`, `adr_en`, `ad_oe`, `mem_rd` and `mem_wr` stay low while a request waits for the grant, however long that wait is.
- R11: A pulse on `tx_ld` or `rx_ld` loads `ld_addr` into that channel's counter. The next transfer of that channel uses the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| mrst | input | 1 | Master reset, active high, synchronous |
| pol_low | input | 1 | 1: request/grant active-low; 0: active-high |
| bus_req_o | output | 1 | Bus request, polarity set by pol_low |
| bus_gnt_i | input | 1 | Bus grant, polarity set by pol_low |
| tx_valid | input | 1 | Transmit channel wants one byte read |
| tx_ready | output | 1 | Transmit byte delivered this cycle |
| tx_byte | output | 8 | Byte read from memory |
| tx_ld | input | 1 | Load transmit address counter |
| rx_valid | input | 1 | Receive channel offers one byte |
| rx_ready | output | 1 | Receive byte written this cycle |
| rx_byte | input | 8 | Byte to write to memory |
| rx_ld | input | 1 | Load receive address counter |
| ld_addr | input | 16 | Value for counter loads |
| mem_a_lo | output | 8 | Low address byte |
| ad_o | output | 8 | Shared bus: high address, then write data |
| ad_i | input | 8 | Shared bus input: read data |
| ad_oe | output | 1 | Drive enable for ad_o |
| adr_strobe | output | 1 | Latches the high address externally |
| adr_en | output | 1 | Enables the external address latch outputs |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| bus_oe | output | 1 | Enable for mem_a_lo, mem_rd and mem_wr |

## Verification
A wrong internal state shows at the ports within the same transfer. A counter that fails to step, or that carries wrongly, puts a bad value on `mem_a_lo` or on the high byte in the very next address phase of that channel. An arbitration order bit that goes stale sends the ready pulse to the wrong channel in the release phase, about four clocks after the grant. A phase register that skips or repeats a state shows up at once as a strobe in the wrong cycle, or as a bus request that is still active in the cycle after release.

// File: rtl/twin_dma_pkg.sv
package twin_dma_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_REQ  = 3'd1,
    PH_ADDR = 3'd2,
    PH_STRB = 3'd3,
    PH_REL  = 3'd4
  } phase_t;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int NCH   = 2;
endpackage

// File: rtl/dma2_addr_ctr.sv
module dma2_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (mrst)      addr <= '0;
    else if (ld)   addr <= ld_val;
    else if (step) addr <= addr + AW'(1);
  end

  // R9
  step_inc_chk: assert property (@(posedge clk) disable iff (mrst)
    (step && !ld) |=> (addr == $past(addr) + AW'(1)));

  // R11
  load_take_chk: assert property (@(posedge clk) disable iff (mrst)
    ld |=> (addr == $past(ld_val)));
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb (
  input  logic clk,
  input  logic mrst,
  input  logic tx_req,
  input  logic rx_req,
  input  logic tx_ack,
  input  logic rx_ack,
  output logic any_req,
  output logic pick_rx
);
  logic tx_older;
  logic tx_live, rx_live, pick_tx;

  // a request acknowledged this cycle is consumed; a held valid is a new one
  assign tx_live = tx_req && !tx_ack;
  assign rx_live = rx_req && !rx_ack;
  assign pick_tx = tx_live && (!rx_live || tx_older);
  assign pick_rx = rx_live && !pick_tx;
  assign any_req = tx_live || rx_live;

  always_ff @(posedge clk) begin
    if (mrst) tx_older <= 1'b0;
    else      tx_older <= tx_live && (!rx_live || tx_older);
  end

  // R7
  tie_rx_chk: assert property (@(posedge clk) disable iff (mrst)
    (tx_req && rx_req && !$past(tx_req) && !$past(rx_req)) |-> pick_rx);
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq import twin_dma_pkg::*; (
  input  logic   clk,
  input  logic   mrst,
  input  logic   any_req,
  input  logic   pick_rx,
  input  logic   gnt_act,
  output phase_t phase,
  output logic   sel_rx
);
  always_ff @(posedge clk) begin
    if (mrst) begin
      phase  <= PH_IDLE;
      sel_rx <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (any_req) begin
          phase  <= PH_REQ;
          sel_rx <= pick_rx;
        end
        PH_REQ:  if (gnt_act) phase <= PH_ADDR;
        PH_ADDR: phase <= PH_STRB;
        PH_STRB: phase <= PH_REL;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3
  addr_then_strb_chk: assert property (@(posedge clk) disable iff (mrst)
    (phase == PH_ADDR) |=> (phase == PH_STRB && sel_rx == $past(sel_rx)));
endmodule

// File: rtl/twin_byte_dma.sv
module twin_byte_dma import twin_dma_pkg::*; #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            mrst,
  input  logic            pol_low,
  output logic            bus_req_o,
  input  logic            bus_gnt_i,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [DW-1:0]   tx_byte,
  input  logic            tx_ld,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_byte,
  input  logic            rx_ld,
  input  logic [2*DW-1:0] ld_addr,
  output logic [DW-1:0]   mem_a_lo,
  output logic [DW-1:0]   ad_o,
  input  logic [DW-1:0]   ad_i,
  output logic            ad_oe,
  output logic            adr_strobe,
  output logic            adr_en,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            bus_oe
);
  localparam int AW = 2 * DW;

  phase_t          phase;
  logic            sel_rx, pick_rx, any_req, gnt_act, req_act, in_bus, data_ph;
  logic [NCH-1:0]  ld_v, step_v;
  logic [AW-1:0]   addr_q [NCH];
  logic [AW-1:0]   cur_addr;

  assign gnt_act   = bus_gnt_i ^ pol_low;
  assign req_act   = (phase != PH_IDLE);
  assign bus_req_o = req_act ^ pol_low;

  dma2_arb u_arb (
    .clk     (clk),
    .mrst    (mrst),
    .tx_req  (tx_valid),
    .rx_req  (rx_valid),
    .tx_ack  (tx_ready),
    .rx_ack  (rx_ready),
    .any_req (any_req),
    .pick_rx (pick_rx)
  );

  dma2_seq u_seq (
    .clk     (clk),
    .mrst    (mrst),
    .any_req (any_req),
    .pick_rx (pick_rx),
    .gnt_act (gnt_act),
    .phase   (phase),
    .sel_rx  (sel_rx)
  );

  assign ld_v[CH_TX]   = tx_ld;
  assign ld_v[CH_RX]   = rx_ld;
  assign step_v[CH_TX] = tx_ready;
  assign step_v[CH_RX] = rx_ready;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2_addr_ctr #(.AW(AW)) u_ctr (
      .clk    (clk),
      .mrst   (mrst),
      .ld     (ld_v[c]),
      .ld_val (ld_addr),
      .step   (step_v[c]),
      .addr   (addr_q[c])
    );
  end

  assign cur_addr   = sel_rx ? addr_q[CH_RX] : addr_q[CH_TX];
  assign in_bus     = (phase == PH_ADDR) || (phase == PH_STRB) || (phase == PH_REL);
  assign data_ph    = (phase == PH_STRB) || (phase == PH_REL);

  assign bus_oe     = in_bus;
  assign adr_en     = in_bus;
  assign adr_strobe = (phase == PH_ADDR);
  assign mem_a_lo   = in_bus ? cur_addr[DW-1:0] : '0;
  assign ad_oe      = (phase == PH_ADDR) || (sel_rx && data_ph);
  assign ad_o       = (phase == PH_ADDR)  ? cur_addr[AW-1:DW] :
                      (sel_rx && data_ph) ? rx_byte : '0;
  assign mem_rd     = (phase == PH_STRB) && !sel_rx;
  assign mem_wr     = (phase == PH_STRB) && sel_rx;
  assign tx_ready   = (phase == PH_REL) && !sel_rx;
  assign rx_ready   = (phase == PH_REL) && sel_rx;

  always_ff @(posedge clk) begin
    if (mrst)        tx_byte <= '0;
    else if (mem_rd) tx_byte <= ad_i;
  end

  // R10
  drive_needs_grant_chk: assert property (@(posedge clk) disable iff (mrst)
    bus_oe |-> gnt_act);

  // R3
  release_drop_chk: assert property (@(posedge clk) disable iff (mrst)
    (tx_ready || rx_ready) |=> !(bus_req_o ^ pol_low));

  // R6
  single_ready_chk: assert property (@(posedge clk) disable iff (mrst)
    (tx_ready || rx_ready) |=> !(tx_ready || rx_ready));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (mrst)
    $onehot0({mem_rd, mem_wr, adr_strobe}));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(mrst) |-> (!bus_oe && !tx_ready && !rx_ready));
endmodule

// File: tb/twin_byte_dma_tb.sv
module twin_byte_dma_tb_top;
  logic        clk = 1'b0;
  logic        mrst = 1'b1;
  logic        pol_low = 1'b0;
  logic        bus_req_o;
  logic        bus_gnt_i = 1'b0;
  logic        tx_valid = 1'b0, rx_valid = 1'b0;
  logic        tx_ready, rx_ready;
  logic [7:0]  tx_byte;
  logic [7:0]  rx_byte = 8'h00;
  logic        tx_ld = 1'b0, rx_ld = 1'b0;
  logic [15:0] ld_addr = 16'h0000;
  logic [7:0]  mem_a_lo, ad_o;
  logic [7:0]  ad_i = 8'h00;
  logic        ad_oe, adr_strobe, adr_en, mem_rd, mem_wr, bus_oe;

  int nvec = 0, nbad = 0;
  int left_tx = 0, left_rx = 0;
  logic [15:0] m_tx = 16'h0000, m_rx = 16'h0000;
  logic [7:0]  cur_rb = 8'h00;

  // {pol_low, scenario[2:0], read byte, write byte}
  // scenario: 0 both together, 1 tx first, 2 rx first, 3 tx only, 4 rx only
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 3'd0, 8'h5A, 8'hC3},
    {1'b0, 3'd1, 8'h81, 8'h7E},
    {1'b1, 3'd2, 8'h3C, 8'hE1},
    {1'b1, 3'd0, 8'hF0, 8'h0F},
    {1'b0, 3'd3, 8'h99, 8'h66},
    {1'b1, 3'd4, 8'h12, 8'h34}
  };

  always #4 clk = ~clk;

  twin_byte_dma dut_i (
    .clk(clk), .mrst(mrst), .pol_low(pol_low), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_ld(tx_ld),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte), .rx_ld(rx_ld),
    .ld_addr(ld_addr), .mem_a_lo(mem_a_lo), .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe),
    .adr_strobe(adr_strobe), .adr_en(adr_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic bit req_on();
    return bus_req_o ^ pol_low;
  endfunction

  task automatic set_gnt(input bit a);
    bus_gnt_i = a ^ pol_low;
  endtask

  task automatic load(input bit rx, input logic [15:0] v);
    ld_addr = v;
    if (rx) begin rx_ld = 1'b1; m_rx = v; end
    else    begin tx_ld = 1'b1; m_tx = v; end
    tick;
    tx_ld = 1'b0; rx_ld = 1'b0;
  endtask

  // late: 1 raises tx, 2 raises rx while the current request waits
  task automatic serve(input bit exp_rx, input int late, input int hold);
    logic [15:0] ea;
    int w = 0;
    while (!req_on() && w < 30) begin tick; w++; end
    chk(req_on(), "R6 request raised", req_on(), 1);
    chk(bus_req_o == !pol_low, "R2 request pin level", bus_req_o, !pol_low);
    if (late == 1) begin tx_valid = 1'b1; left_tx++; end
    if (late == 2) begin rx_valid = 1'b1; left_rx++; end
    for (int h = 0; h < hold; h++) begin
      tick;
      chk(req_on() && !bus_oe && !adr_en && !ad_oe && !mem_rd && !mem_wr,
          "R10 quiet while waiting", {bus_oe, ad_oe, mem_rd, mem_wr}, 0);
    end
    ea = exp_rx ? m_rx : m_tx;
    ad_i = cur_rb;
    set_gnt(1'b1);
    tick;
    chk(adr_strobe && adr_en && ad_oe && bus_oe && !mem_rd && !mem_wr,
        "R3 address phase", {adr_strobe, adr_en, ad_oe, bus_oe, mem_rd, mem_wr}, 6'b111100);
    chk(ad_o == ea[15:8], "R3 high address byte", ad_o, ea[15:8]);
    chk(mem_a_lo == ea[7:0], "R9 low address byte", mem_a_lo, ea[7:0]);
    tick;
    if (exp_rx) begin
      chk(mem_wr && !mem_rd && ad_oe, "R5 write strobe", {mem_wr, mem_rd, ad_oe}, 3'b101);
      chk(ad_o == rx_byte, "R5 write data", ad_o, rx_byte);
    end else begin
      chk(mem_rd && !mem_wr && !ad_oe, "R4 read strobe", {mem_rd, mem_wr, ad_oe}, 3'b100);
    end
    chk(!adr_strobe, "R3 strobe one cycle", adr_strobe, 0);
    tick;
    chk(exp_rx ? (rx_ready && !tx_ready) : (tx_ready && !rx_ready),
        "R7 R8 order / R6 single ready", {rx_ready, tx_ready}, exp_rx ? 2 : 1);
    chk(!mem_rd && !mem_wr, "R3 release phase", {mem_rd, mem_wr}, 0);
    if (!exp_rx) chk(tx_byte == cur_rb, "R4 read data", tx_byte, cur_rb);
    if (exp_rx) begin
      m_rx = m_rx + 16'd1; left_rx--;
      if (left_rx <= 0) rx_valid = 1'b0;
    end else begin
      m_tx = m_tx + 16'd1; left_tx--;
      if (left_tx <= 0) tx_valid = 1'b0;
    end
    tick;
    chk(!req_on() && !bus_oe && !tx_ready && !rx_ready, "R3 request dropped", req_on(), 0);
    set_gnt(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    chk(!bus_req_o && !bus_oe && !ad_oe && !mem_rd && !mem_wr && !tx_ready && !rx_ready,
        "R1 reset state", {bus_req_o, bus_oe, ad_oe, mem_rd, mem_wr}, 0);
    mrst = 1'b0;
    tick;
    chk(!bus_req_o && !bus_oe, "R1 idle after reset", {bus_req_o, bus_oe}, 0);

    // R1: counters start at zero
    cur_rb = 8'hA5; tx_valid = 1'b1; left_tx = 1;
    serve(1'b0, 0, 0);
    rx_byte = 8'h4B; rx_valid = 1'b1; left_rx = 1;
    serve(1'b1, 0, 0);

    // R11 loads, with carry out of the low byte covered by R9
    load(1'b0, 16'h12FE);
    load(1'b1, 16'hABFF);

    for (int vi = 0; vi < 6; vi++) begin
      pol_low = VEC[vi][19];
      set_gnt(1'b0);
      tick;
      cur_rb  = VEC[vi][15:8];
      rx_byte = VEC[vi][7:0];
      case (VEC[vi][18:16])
        3'd0: begin
          left_tx = 1; left_rx = 1; tx_valid = 1'b1; rx_valid = 1'b1;
          serve(1'b1, 0, 0); serve(1'b0, 0, 0);
        end
        3'd1: begin
          left_tx = 2; tx_valid = 1'b1;
          serve(1'b0, 2, 0); serve(1'b1, 0, 0); serve(1'b0, 0, 0);
        end
        3'd2: begin
          left_rx = 2; rx_valid = 1'b1;
          serve(1'b1, 1, 0); serve(1'b0, 0, 0); serve(1'b1, 0, 0);
        end
        3'd3: begin
          left_tx = 1; tx_valid = 1'b1; serve(1'b0, 0, 0);
        end
        default: begin
          left_rx = 1; rx_valid = 1'b1; serve(1'b1, 0, 0);
        end
      endcase
    end

    // R10: grant withheld for several cycles
    pol_low = 1'b0; set_gnt(1'b0); tick;
    rx_byte = 8'hD2; rx_valid = 1'b1; left_rx = 1;
    serve(1'b1, 0, 5);

    // R9: wrap of the full counter
    load(1'b0, 16'hFFFF);
    cur_rb = 8'h77; tx_valid = 1'b1; left_tx = 2;
    serve(1'b0, 0, 0); serve(1'b0, 0, 0);
    chk(m_tx == 16'h0001, "R9 wrap model", m_tx, 16'h0001);

    // R1: reset in the middle of a transfer
    load(1'b1, 16'h4444);
    rx_valid = 1'b1;
    tick; tick;
    set_gnt(1'b1);
    tick;
    chk(adr_strobe, "R1 transfer started", adr_strobe, 1);
    mrst = 1'b1; rx_valid = 1'b0;
    tick;
    chk(!bus_req_o && !bus_oe && !mem_wr && !rx_ready, "R1 reset aborts",
        {bus_req_o, bus_oe, mem_wr, rx_ready}, 0);
    mrst = 1'b0; set_gnt(1'b0); m_rx = 16'h0000; m_tx = 16'h0000;
    tick;
    rx_byte = 8'h5E; rx_valid = 1'b1; left_rx = 1;
    serve(1'b1, 0, 0);

    repeat (2) tick;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule